// File: doc/BRIEF.md
# Multiprocessor-Addressed Asynchronous Receiver

This block receives asynchronous serial frames from a single line and hands them to software through a one-deep data register with a full flag. Each frame holds eight data bits, least significant first. The data bits can be followed by an optional ninth bit, and the frame ends with one stop bit. Bits are sampled at their centre using a baud enable that pulses sixteen times per bit period. The baud enable comes from outside the block.

In normal mode the ninth bit, when enabled, is a parity bit, with even or odd sense. In multiprocessor mode the ninth bit marks each frame as a station address (1) or as payload (0). The receiver ignores payload until an address frame arrives whose data equals the configured station ID. It then passes that address frame on, tagged as an address, and accepts the payload frames that follow. An address frame that does not match is dropped and ends acceptance. Unaccepted frames never touch the data register or the full flag.

Top module: `mpx_uart_rx`

## Requirements
- R1: The idle line is 1. A 0 seen on a baud tick starts a frame. Eight data bits are taken least significant first, at mid-bit. A stop bit of 1 then loads `rx_data` and sets `rx_full`.
- R2: If the start bit is no longer 0 when sampled at its centre (the eighth tick after it was detected), the receiver goes back to idle without loading anything.
- R3: A stop bit sampled as 0 sets `frame_err` and does not load data. The receiver then waits for the line to return to 1 before it looks for a new start bit.
- R4: With `parity_en`=1 and `mp_mode`=0, a ninth bit follows the data. `parity_odd`=0 requires an even number of ones across the data and parity bits; `parity_odd`=1 requires an odd number. On a mismatch `parity_err` is set and nothing is loaded.
- R5: With `mp_mode`=1, a ninth bit always follows the data. While the receiver is not addressed, frames whose ninth bit is 0 are dropped.
- R6: In `mp_mode`, a frame whose ninth bit is 1 and whose data equals `station_id` is loaded with `rx_is_addr`=1. The receiver then becomes addressed, and the payload frames (ninth bit 0) that follow are loaded with `rx_is_addr`=0.
- R7: In `mp_mode`, a frame whose ninth bit is 1 and whose data differs from `station_id` is dropped. The receiver becomes unaddressed, so later payload frames are dropped as well.
- R8: If an accepted frame completes while `rx_full` is 1, `overrun` is set and `rx_data` keeps its old value.
- R9: `rx_full` stays set until a cycle with `rx_clear`=1. `irq_rx` equals `rx_full`.
- R10: `frame_err`, `parity_err` and `overrun` stay set until `err_clear`=1. `irq_err` is 1 exactly when any of them is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial data line, already synchronised |
| tick16 | input | 1 | Baud enable, sixteen pulses per bit |
| parity_en | input | 1 | Normal mode: a parity bit follows the data |
| parity_odd | input | 1 | Parity sense: 0 even, 1 odd |
| mp_mode | input | 1 | Select multiprocessor addressing mode |
| station_id | input | 8 | Local station address |
| rx_clear | input | 1 | Strobe that empties the data register |
| err_clear | input | 1 | Strobe that clears all error flags |
| rx_data | output | 8 | Received data |
| rx_is_addr | output | 1 | Held data came from a matching address frame |
| rx_full | output | 1 | Data register holds unread data |
| overrun | output | 1 | An accepted frame was lost because the register was full |
| frame_err | output | 1 | A stop bit was sampled as 0 |
| parity_err | output | 1 | A parity check failed |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The bench sends a start pulse that returns high before mid-bit. A receiver that trusts the falling edge would assemble a frame of ones out of the idle line. It sends a zero stop bit. A design that re-armed at once would treat the rest of that stop bit as a new start and deliver a false frame. In multiprocessor mode it sends payload before any address, then a non-matching address, then payload again. A filter that leaks delivers those frames, and one that fails to deassert keeps accepting after the mismatch. The overrun case leaves the first frame unread and checks that the second frame neither overwrites it nor goes unreported.

// File: rtl/mpx_uart_rx.sv
module mpx_uart_rx #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd,
  input  logic          tick16,
  input  logic          parity_en,
  input  logic          parity_odd,
  input  logic          mp_mode,
  input  logic [DW-1:0] station_id,
  input  logic          rx_clear,
  input  logic          err_clear,
  output logic [DW-1:0] rx_data,
  output logic          rx_is_addr,
  output logic          rx_full,
  output logic          overrun,
  output logic          frame_err,
  output logic          parity_err,
  output logic          irq_rx,
  output logic          irq_err
);
  localparam int CW  = $clog2(OVS);
  localparam int BW  = $clog2(DW);
  localparam int MID = OVS / 2 - 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_XBIT, S_STOP, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW-1:0] sh;
  logic          xb, addressed;

  wire last    = (cnt == CW'(OVS - 1));
  wire xused   = mp_mode | parity_en;
  wire par_ok  = ((^sh) ^ xb) == parity_odd;
  wire stop_ev = tick16 && (st == S_STOP) && last;
  wire good    = stop_ev && rxd && (mp_mode || !parity_en || par_ok);
  wire id_hit  = (sh == station_id);
  wire deliver = good && (!mp_mode || (xb ? id_hit : addressed));

  assign irq_rx  = rx_full;
  assign irq_err = frame_err | parity_err | overrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; sh <= '0; xb <= 1'b0;
      addressed <= 1'b0; rx_data <= '0; rx_is_addr <= 1'b0; rx_full <= 1'b0;
      overrun <= 1'b0; frame_err <= 1'b0; parity_err <= 1'b0;
    end else begin
      if (tick16) begin
        case (st)
          S_IDLE:  if (!rxd) begin st <= S_START; cnt <= '0; end
          S_START: begin
            if (cnt == CW'(MID)) begin
              cnt  <= '0;
              bitn <= '0;
              st   <= rxd ? S_IDLE : S_DATA;
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            cnt <= cnt + 1'b1;
            if (last) begin
              sh   <= {rxd, sh[DW-1:1]};
              bitn <= bitn + 1'b1;
              if (bitn == BW'(DW - 1)) st <= xused ? S_XBIT : S_STOP;
            end
          end
          S_XBIT: begin
            cnt <= cnt + 1'b1;
            if (last) begin xb <= rxd; st <= S_STOP; end
          end
          S_STOP: begin
            cnt <= cnt + 1'b1;
            if (last) st <= rxd ? S_IDLE : S_HOLD;
          end
          default: if (rxd) st <= S_IDLE;
        endcase
      end

      if (err_clear) begin
        frame_err <= 1'b0; parity_err <= 1'b0; overrun <= 1'b0;
      end
      if (stop_ev && !rxd) frame_err <= 1'b1;
      if (stop_ev && rxd && !mp_mode && parity_en && !par_ok) parity_err <= 1'b1;
      if (deliver && rx_full) overrun <= 1'b1;

      if (deliver && !rx_full) begin
        rx_data    <= sh;
        rx_is_addr <= mp_mode & xb;
        rx_full    <= 1'b1;
      end else if (rx_clear) rx_full <= 1'b0;

      if (!mp_mode) addressed <= 1'b0;
      else if (good && xb) addressed <= id_hit;
    end
  end
endmodule

// File: rtl/mpx_uart_rx_chk.sv
module mpx_uart_rx_chk #(parameter int DW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          rxd,
  input logic          mp_mode,
  input logic          rx_clear,
  input logic          err_clear,
  input logic [DW-1:0] rx_data,
  input logic          rx_is_addr,
  input logic          rx_full,
  input logic          overrun,
  input logic          frame_err
);
  a_r1_load_after_high_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(rxd));

  a_r8_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && $past(rx_full)) |-> (rx_data == $past(rx_data)));

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clear && rx_full) |=> !rx_full);

  a_r3_frame_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !err_clear) |=> frame_err);

  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !err_clear) |=> overrun);

  a_r6_addr_tag_needs_mp: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_full) && rx_is_addr) |-> $past(mp_mode));
endmodule

bind mpx_uart_rx mpx_uart_rx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rxd(rxd), .mp_mode(mp_mode),
  .rx_clear(rx_clear), .err_clear(err_clear), .rx_data(rx_data),
  .rx_is_addr(rx_is_addr), .rx_full(rx_full), .overrun(overrun),
  .frame_err(frame_err)
);

// File: tb/test_mpx_uart_rx.sv
module test_mpx_uart_rx;
  logic clk = 0, rst_n = 0, rxd = 1, tick16 = 0;
  logic parity_en = 0, parity_odd = 0, mp_mode = 0;
  logic [7:0] station_id = 8'h5A;
  logic rx_clear = 0, err_clear = 0;
  logic [7:0] rx_data;
  logic rx_is_addr, rx_full, overrun, frame_err, parity_err, irq_rx, irq_err;

  int  n_chk = 0, n_bad = 0;
  bit  hold = 0, done = 0;
  logic [8:0] expq[$];

  always #2.5 clk = ~clk;
  always @(negedge clk) tick16 <= ~tick16;

  mpx_uart_rx i_mpx_uart_rx (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bitt(input logic v);
    rxd = v;
    repeat (32) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit has_x, input bit xv,
                      input bit sv, input bit exp, input bit ea);
    if (exp) expq.push_back({ea, d});
    bitt(1'b0);
    for (int i = 0; i < 8; i++) bitt(d[i]);
    if (has_x) bitt(xv);
    bitt(sv);
    bitt(1'b1);
    bitt(1'b1);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      chk(irq_rx == rx_full, "R9 irq_rx", irq_rx, rx_full);
      if (rx_full && !hold && !rx_clear) begin
        if (expq.size() == 0)
          chk(0, "R1/R5/R7 unexpected delivery", rx_data, 0);
        else begin
          logic [8:0] e;
          e = expq.pop_front();
          chk({rx_is_addr, rx_data} == e, "R1/R6 delivered item", {rx_is_addr, rx_data}, e);
        end
        rx_clear = 1;
      end else rx_clear = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(rx_full == 0 && irq_err == 0 && overrun == 0, "R9 reset state", rx_full, 0);
    rst_n = 1;
    repeat (8) @(negedge clk);

    // R1 normal frames
    send(8'hA5, 0, 0, 1, 1, 0);
    send(8'h3C, 0, 0, 1, 1, 0);
    send(8'h00, 0, 0, 1, 1, 0);
    send(8'hFF, 0, 0, 1, 1, 0);

    // R2 short start pulse ignored
    rxd = 0; repeat (8) @(negedge clk);
    rxd = 1; repeat (64) @(negedge clk);
    chk(rx_full == 0, "R2 glitch ignored", rx_full, 0);
    send(8'h81, 0, 0, 1, 1, 0);

    // R3 framing error, then recovery
    send(8'h55, 0, 0, 0, 0, 0);
    chk(frame_err == 1, "R3 frame_err", frame_err, 1);
    chk(irq_err == 1, "R10 irq_err on frame error", irq_err, 1);
    chk(rx_full == 0, "R3 no load", rx_full, 0);
    err_clear = 1; @(negedge clk); err_clear = 0;
    chk(frame_err == 0 && irq_err == 0, "R10 err_clear", irq_err, 0);
    send(8'h42, 0, 0, 1, 1, 0);

    // R4 parity
    parity_en = 1;
    send(8'hA5, 1, 0, 1, 1, 0);
    send(8'hA5, 1, 1, 1, 0, 0);
    chk(parity_err == 1, "R4 parity_err even", parity_err, 1);
    chk(rx_full == 0, "R4 bad parity not loaded", rx_full, 0);
    err_clear = 1; @(negedge clk); err_clear = 0;
    parity_odd = 1;
    send(8'h01, 1, 0, 1, 1, 0);
    chk(parity_err == 0, "R4 odd parity accepted", parity_err, 0);
    parity_en = 0; parity_odd = 0;

    // R5..R7 multiprocessor addressing
    mp_mode = 1;
    send(8'h10, 1, 0, 1, 0, 0);
    chk(rx_full == 0, "R5 unaddressed payload dropped", rx_full, 0);
    send(8'h33, 1, 1, 1, 0, 0);
    send(8'h20, 1, 0, 1, 0, 0);
    chk(rx_full == 0, "R7 mismatched id dropped", rx_full, 0);
    send(8'h5A, 1, 1, 1, 1, 1);
    send(8'h77, 1, 0, 1, 1, 0);
    send(8'h78, 1, 0, 1, 1, 0);
    send(8'h33, 1, 1, 1, 0, 0);
    send(8'h99, 1, 0, 1, 0, 0);
    chk(rx_full == 0, "R7 deaddressed after mismatch", rx_full, 0);
    mp_mode = 0;

    // R8 overrun
    hold = 1;
    send(8'h11, 0, 0, 1, 1, 0);
    chk(rx_full == 1, "R9 full held without clear", rx_full, 1);
    send(8'h22, 0, 0, 1, 0, 0);
    chk(overrun == 1, "R8 overrun set", overrun, 1);
    chk(rx_data == 8'h11, "R8 old data kept", rx_data, 8'h11);
    hold = 0;
    repeat (8) @(negedge clk);
    chk(expq.size() == 0, "R1 all expected delivered", expq.size(), 0);
    err_clear = 1; @(negedge clk); err_clear = 0;
    chk(overrun == 0 && irq_err == 0, "R10 overrun cleared", overrun, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule